// File: doc/BRIEF.md
# Command Packet Stream Parser

This block sits behind a ring fetch unit and turns a flat stream of 32-bit command words into tagged payload beats. Every word it accepts in the header state is classified by its top nibble as a register-write packet, an opcode packet or a single-word no-op. For the two packet kinds that carry data, the header announces a count, and the parser forwards exactly that many following words downstream. Each forwarded word is tagged either with a register address that advances by one per word, or with the packet's opcode.

Headers carry odd-parity bits that protect their count, register index and opcode fields. A header whose parity does not check raises a one-cycle error pulse. The words it announces are then swallowed without output, and parsing picks up again at the word that follows them. A header with an unknown type code raises a separate one-cycle pulse and is dropped by itself. Both the input and the output use valid/ready handshakes. The output holds one registered beat. The parser does not execute opcodes, write registers or fetch memory.

Top module: `cmd_stream_parser`

## Requirements
- R1: Header bits 31:28 select the packet type: 4 is register write, 7 is opcode, 2 is no-op. Any other code pulses err_type for one cycle, in the cycle after the word is accepted. That word produces no output, and the next word is parsed as a header.
- R2: In a register-write header, bits 6:0 hold the count and bit 7 holds its parity bit. Bits 25:8 hold an 18-bit register index and bit 27 holds its parity bit. Each parity bit makes the total number of ones in its field plus the bit odd.
- R3: In an opcode header, bits 14:0 hold the count and bit 15 holds its parity bit. Bits 22:16 hold a 7-bit opcode and bit 23 holds its parity bit. Both parity bits are odd.
- R4: A register-write packet with count N emits N beats with out_is_op=0 and out_has_data=1. Beat i carries payload word i and the address (index + i) modulo 2^18. Counts up to 127 are supported.
- R5: An opcode packet with count N greater than 0 emits N beats with out_is_op=1, out_has_data=1, the header's opcode and the payload words in order.
- R6: An opcode packet with count 0 emits one event with out_is_op=1, out_has_data=0, out_last=1 and its opcode. A register-write packet with count 0 emits nothing.
- R7: A no-op header (type 2) produces no output and no error, and the next word is parsed as a header.
- R8: A register-write or opcode header with any parity mismatch pulses err_parity for one cycle, in the cycle after the header is accepted. The announced count of following words is consumed with no output, whatever those words contain, and the word after them is parsed as a header.
- R9: out_last is 1 on the final beat of each packet and 0 on every other beat.
- R10: While out_valid=1 and out_ready=0, out_valid stays 1 and every output field stays stable. No beat is lost or duplicated under any out_ready pattern.
- R11: During reset, out_valid, err_parity and err_type are 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command word valid |
| in_ready | output | 1 | Parser accepts the command word |
| in_word | input | 32 | Command word from the ring |
| out_valid | output | 1 | Beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_is_op | output | 1 | 1 = opcode packet, 0 = register write |
| out_addr | output | 18 | Register address (register-write beats) |
| out_opcode | output | 7 | Opcode (opcode beats) |
| out_data | output | 32 | Payload word |
| out_has_data | output | 1 | 0 on a zero-count opcode event |
| out_last | output | 1 | Final beat of the packet |
| err_parity | output | 1 | One-cycle pulse on a header parity mismatch |
| err_type | output | 1 | One-cycle pulse on an unknown type code |

## Verification
The parser is driven with register-write packets of short, wrapping and maximum length, with opcode packets of nonzero and zero count, and with no-op words placed between packets. These patterns separate the address-increment path from the opcode tagging path, and they exercise the zero-count special cases. Corrupted headers are followed by payload words that are themselves well-formed headers, so a parser that resynchronises too early emits spurious beats. Corruption of the count parity and of the opcode parity is each tried on its own. A long packet is run under a throttled out_ready to show that beats are held stable and that none is lost or repeated.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;
  localparam int WORD_W   = 32;
  localparam int REGIDX_W = 18;
  localparam int OPC_W    = 7;
  localparam int RCNT_W   = 7;
  localparam int OCNT_W   = 15;
  localparam int CNT_W    = OCNT_W;

  localparam logic [3:0] TYPE_NOP = 4'h2;
  localparam logic [3:0] TYPE_REG = 4'h4;
  localparam logic [3:0] TYPE_OP  = 4'h7;

  typedef enum logic [1:0] {PK_NOP, PK_REG, PK_OP, PK_BAD} pkt_kind_e;

  typedef struct packed {
    logic                is_op;
    logic [REGIDX_W-1:0] addr;
    logic [OPC_W-1:0]    opcode;
    logic [WORD_W-1:0]   data;
    logic                has_data;
    logic                last;
  } beat_t;

  // Odd-parity bit for a field: fold into one nibble, index the constant.
  function automatic logic odd_par(input logic [31:0] v);
    logic [3:0] f;
    f = v[3:0] ^ v[7:4] ^ v[11:8] ^ v[15:12] ^ v[19:16] ^ v[23:20] ^ v[27:24] ^ v[31:28];
    return 16'h9669 >> f;
  endfunction
endpackage

// File: rtl/cmdp_hdr_decode.sv
module cmdp_hdr_decode
  import cmdp_pkg::*;
(
  input  logic [WORD_W-1:0]   word,
  output pkt_kind_e           kind,
  output logic [CNT_W-1:0]    count,
  output logic [REGIDX_W-1:0] reg_idx,
  output logic [OPC_W-1:0]    opcode,
  output logic                par_ok
);
  logic reg_cnt_ok, reg_idx_ok, op_cnt_ok, op_opc_ok;

  always_comb begin
    reg_cnt_ok = (odd_par(32'(word[RCNT_W-1:0])) == word[7]);
    reg_idx_ok = (odd_par(32'(word[25:8])) == word[27]);
    op_cnt_ok  = (odd_par(32'(word[OCNT_W-1:0])) == word[15]);
    op_opc_ok  = (odd_par(32'(word[22:16])) == word[23]);
    kind    = PK_BAD;
    count   = '0;
    reg_idx = '0;
    opcode  = '0;
    par_ok  = 1'b1;
    case (word[31:28])
      TYPE_NOP: kind = PK_NOP;
      TYPE_REG: begin
        kind    = PK_REG;
        count   = CNT_W'(word[RCNT_W-1:0]);
        reg_idx = word[25:8];
        par_ok  = reg_cnt_ok && reg_idx_ok;
      end
      TYPE_OP: begin
        kind   = PK_OP;
        count  = word[OCNT_W-1:0];
        opcode = word[22:16];
        par_ok = op_cnt_ok && op_opc_ok;
      end
      default: kind = PK_BAD;
    endcase
  end
endmodule

// File: rtl/cmdp_seq.sv
module cmdp_seq
  import cmdp_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [WORD_W-1:0]   in_word,
  input  pkt_kind_e           kind,
  input  logic [CNT_W-1:0]    count,
  input  logic [REGIDX_W-1:0] reg_idx,
  input  logic [OPC_W-1:0]    opcode,
  input  logic                par_ok,
  input  logic                slot_free,
  output logic                load,
  output beat_t               ld_beat,
  output logic                err_parity,
  output logic                err_type
);
  typedef enum logic [1:0] {ST_HDR, ST_PAY, ST_SKIP} st_e;

  st_e                 st;
  logic [CNT_W-1:0]    cnt;
  logic [REGIDX_W-1:0] addr;
  logic [OPC_W-1:0]    opc_q;
  logic                is_op_q;
  logic                fire, hdr_fire, pay_fire, skip_fire, hdr_bad_par, hdr_open;

  assign in_ready    = (st == ST_SKIP) || slot_free;
  assign fire        = in_valid && in_ready;
  assign hdr_fire    = fire && (st == ST_HDR);
  assign pay_fire    = fire && (st == ST_PAY);
  assign skip_fire   = fire && (st == ST_SKIP);
  assign hdr_bad_par = hdr_fire && (kind == PK_REG || kind == PK_OP) && !par_ok;
  assign hdr_open    = hdr_fire && (kind == PK_REG || kind == PK_OP) && par_ok;

  always_comb begin
    load    = 1'b0;
    ld_beat = '0;
    if (pay_fire) begin
      load             = 1'b1;
      ld_beat.is_op    = is_op_q;
      ld_beat.addr     = is_op_q ? '0 : addr;
      ld_beat.opcode   = is_op_q ? opc_q : '0;
      ld_beat.data     = in_word;
      ld_beat.has_data = 1'b1;
      ld_beat.last     = (cnt == CNT_W'(1));
    end else if (hdr_open && kind == PK_OP && count == '0) begin
      load           = 1'b1;
      ld_beat.is_op  = 1'b1;
      ld_beat.opcode = opcode;
      ld_beat.last   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_HDR;
      cnt        <= '0;
      addr       <= '0;
      opc_q      <= '0;
      is_op_q    <= 1'b0;
      err_parity <= 1'b0;
      err_type   <= 1'b0;
    end else begin
      err_parity <= hdr_bad_par;
      err_type   <= hdr_fire && (kind == PK_BAD);
      if (hdr_bad_par && count != '0) begin
        st  <= ST_SKIP;
        cnt <= count;
      end else if (hdr_open && count != '0) begin
        st      <= ST_PAY;
        cnt     <= count;
        addr    <= reg_idx;
        opc_q   <= opcode;
        is_op_q <= (kind == PK_OP);
      end else if (pay_fire || skip_fire) begin
        cnt  <= cnt - CNT_W'(1);
        addr <= addr + REGIDX_W'(1);
        if (cnt == CNT_W'(1)) st <= ST_HDR;
      end
    end
  end

  // R8: no beat is produced while announced words are being discarded
  a_r8_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SKIP) |-> !load);
  // R9: a payload beat flagged last leaves the parser in header state
  a_r9_last_returns: assert property (@(posedge clk) disable iff (!rst_n)
    (load && ld_beat.last) |=> (st == ST_HDR));
endmodule

// File: rtl/cmdp_out_stage.sv
module cmdp_out_stage
  import cmdp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  beat_t ld_beat,
  input  logic  out_ready,
  output logic  out_valid,
  output beat_t beat,
  output logic  slot_free
);
  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      beat      <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      beat      <= ld_beat;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R10: the parser never loads over a beat that is not being taken
  a_r10_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!out_valid || out_ready));
  // R10: a stalled beat is held unchanged
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(beat)));
endmodule

// File: rtl/cmd_stream_parser.sv
module cmd_stream_parser
  import cmdp_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [WORD_W-1:0]   in_word,
  output logic                out_valid,
  input  logic                out_ready,
  output logic                out_is_op,
  output logic [REGIDX_W-1:0] out_addr,
  output logic [OPC_W-1:0]    out_opcode,
  output logic [WORD_W-1:0]   out_data,
  output logic                out_has_data,
  output logic                out_last,
  output logic                err_parity,
  output logic                err_type
);
  pkt_kind_e           kind;
  logic [CNT_W-1:0]    count;
  logic [REGIDX_W-1:0] reg_idx;
  logic [OPC_W-1:0]    opcode;
  logic                par_ok, slot_free, load;
  beat_t               ld_beat, beat;

  cmdp_hdr_decode u_dec (
    .word(in_word), .kind(kind), .count(count), .reg_idx(reg_idx),
    .opcode(opcode), .par_ok(par_ok)
  );

  cmdp_seq u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .kind(kind), .count(count), .reg_idx(reg_idx),
    .opcode(opcode), .par_ok(par_ok), .slot_free(slot_free), .load(load),
    .ld_beat(ld_beat), .err_parity(err_parity), .err_type(err_type)
  );

  cmdp_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_beat(ld_beat),
    .out_ready(out_ready), .out_valid(out_valid), .beat(beat),
    .slot_free(slot_free)
  );

  assign out_is_op    = beat.is_op;
  assign out_addr     = beat.addr;
  assign out_opcode   = beat.opcode;
  assign out_data     = beat.data;
  assign out_has_data = beat.has_data;
  assign out_last     = beat.last;

  // R6: an event without data is always a lone opcode event
  a_r6_empty_event: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_has_data) |-> (out_is_op && out_last));
  // R1: one header cannot be both a type error and a parity error
  a_r1_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_parity && err_type));
endmodule

// File: tb/cmd_stream_parser_bench.sv
`timescale 1ns/1ps
module cmd_stream_parser_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_is_op;
  logic [17:0] out_addr;
  logic [6:0]  out_opcode;
  logic [31:0] out_data;
  logic        out_has_data, out_last, err_parity, err_type;

  always #2.5 clk = ~clk;

  cmd_stream_parser u_cmd_stream_parser (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_is_op(out_is_op), .out_addr(out_addr), .out_opcode(out_opcode),
    .out_data(out_data), .out_has_data(out_has_data), .out_last(out_last),
    .err_parity(err_parity), .err_type(err_type)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit stall = 0;
  int cyc = 0;

  // captured and expected beats: {is_op, addr, opcode, data, has_data, last}
  logic [59:0] cap [0:511];
  logic [59:0] exp_b [0:511];
  int n_cap = 0, n_exp = 0;
  int n_perr = 0, n_terr = 0;
  bit held = 0;
  logic [59:0] held_b;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [59:0] pack(input bit op, input logic [17:0] a,
      input logic [6:0] o, input logic [31:0] d, input bit hd, input bit l);
    return {op, a, o, d, hd, l};
  endfunction

  // odd parity bit: inverted XOR reduction of the field
  function automatic logic [31:0] mk_reg(input logic [17:0] idx, input logic [6:0] c,
                                         input bit bad_c, input bit bad_i);
    logic pc, pi;
    pc = ~(^c) ^ bad_c;
    pi = ~(^idx) ^ bad_i;
    return {4'h4, pi, 1'b0, idx, pc, c};
  endfunction

  function automatic logic [31:0] mk_op(input logic [6:0] o, input logic [14:0] c,
                                        input bit bad_c, input bit bad_o);
    logic pc, po;
    pc = ~(^c) ^ bad_c;
    po = ~(^o) ^ bad_o;
    return {4'h7, 4'h0, po, o, pc, c};
  endfunction

  // monitor at the falling edge, between clock edges
  always @(negedge clk) begin
    if (rst_n) begin
      if (err_parity) n_perr++;
      if (err_type) n_terr++;
      if (held) begin
        chk(out_valid && (pack(out_is_op, out_addr, out_opcode, out_data, out_has_data, out_last) == held_b),
            "R10", "stalled beat held", {59'b0, out_valid}, 1);
      end
      held = out_valid && !out_ready;
      held_b = pack(out_is_op, out_addr, out_opcode, out_data, out_has_data, out_last);
      if (out_valid && out_ready) begin
        if (n_cap < 512) cap[n_cap] = held_b;
        n_cap++;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      out_ready = stall ? (cyc % 3 == 0) : 1'b1;
    end
  end

  task automatic push(input logic [31:0] w);
    in_valid = 1'b1;
    in_word  = w;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic expect_beat(input bit op, input logic [17:0] a, input logic [6:0] o,
                             input logic [31:0] d, input bit hd, input bit l);
    exp_b[n_exp] = pack(op, a, o, d, hd, l);
    n_exp++;
  endtask

  task automatic start_case();
    @(posedge clk);
    #1;
    n_cap = 0; n_exp = 0; n_perr = 0; n_terr = 0;
  endtask

  task automatic finish_case(input string req, input int perr, input int terr);
    repeat (30) @(posedge clk);
    #1;
    chk(n_cap == n_exp, req, "beat count", n_cap, n_exp);
    for (int i = 0; i < n_exp && i < n_cap; i++)
      chk(cap[i] == exp_b[i], req, $sformatf("beat %0d", i), cap[i], exp_b[i]);
    chk(n_perr == perr, req, "err_parity cycles", n_perr, perr);
    chk(n_terr == terr, req, "err_type cycles", n_terr, terr);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!out_valid, "R11", "out_valid in reset", out_valid, 0);
    chk(!err_parity && !err_type, "R11", "errors in reset", {err_parity, err_type}, 0);
    chk(in_ready, "R11", "in_ready in reset", in_ready, 1);
  endtask

  task automatic t_reg_write();   // R2 R4 R9
    start_case();
    push(mk_reg(18'h01234, 7'd3, 0, 0));
    for (int i = 0; i < 3; i++) begin
      push(32'hA000_0000 + i);
      expect_beat(0, 18'(18'h01234 + i), 0, 32'hA000_0000 + i, 1, i == 2);
    end
    push(mk_reg(18'h3FFFF, 7'd2, 0, 0));
    for (int i = 0; i < 2; i++) begin
      push(32'hB000_0000 + i);
      expect_beat(0, 18'(18'h3FFFF + i), 0, 32'hB000_0000 + i, 1, i == 1);
    end
    finish_case("R4", 0, 0);
  endtask

  task automatic t_max_stalled();  // R4 R10 with 127 words
    start_case();
    stall = 1;
    push(mk_reg(18'h00100, 7'd127, 0, 0));
    for (int i = 0; i < 127; i++) begin
      push(32'hC000_0000 ^ (i * 32'h0101));
      expect_beat(0, 18'(18'h00100 + i), 0, 32'hC000_0000 ^ (i * 32'h0101), 1, i == 126);
    end
    finish_case("R10", 0, 0);
    stall = 0;
  endtask

  task automatic t_opcode();   // R3 R5 R6
    start_case();
    push(mk_op(7'h55, 15'd4, 0, 0));
    for (int i = 0; i < 4; i++) begin
      push(32'hD000_0000 + i);
      expect_beat(1, 0, 7'h55, 32'hD000_0000 + i, 1, i == 3);
    end
    push(mk_op(7'h2A, 15'd0, 0, 0));
    expect_beat(1, 0, 7'h2A, 0, 0, 1);
    push(mk_reg(18'h00777, 7'd0, 0, 0));
    push(mk_op(7'h7F, 15'd1, 0, 0));
    push(32'h1234_5678);
    expect_beat(1, 0, 7'h7F, 32'h1234_5678, 1, 1);
    finish_case("R5", 0, 0);
  endtask

  task automatic t_noop();   // R7
    start_case();
    push(32'h2000_0000);
    push(32'h2FFF_FFFF);
    push(mk_reg(18'h00042, 7'd1, 0, 0));
    push(32'h0BAD_F00D);
    expect_beat(0, 18'h00042, 0, 32'h0BAD_F00D, 1, 1);
    finish_case("R7", 0, 0);
  endtask

  task automatic t_parity();   // R8 R2 R3
    start_case();
    push(mk_reg(18'h00010, 7'd2, 1, 0));          // count parity wrong
    push(mk_op(7'h11, 15'd1, 0, 0));              // skipped although well formed
    push(mk_op(7'h12, 15'd0, 0, 0));              // skipped
    push(mk_reg(18'h00020, 7'd1, 0, 1));          // index parity wrong
    push(mk_op(7'h13, 15'd0, 0, 0));              // skipped
    push(mk_op(7'h21, 15'd3, 0, 1));              // opcode parity wrong
    for (int i = 0; i < 3; i++) push(mk_reg(18'h5, 7'd0, 0, 0));
    push(mk_op(7'h22, 15'd0, 1, 0));              // zero count, bad parity
    push(mk_op(7'h30, 15'd1, 0, 0));              // resumes here
    push(32'hE000_0001);
    expect_beat(1, 0, 7'h30, 32'hE000_0001, 1, 1);
    finish_case("R8", 4, 0);
  endtask

  task automatic t_bad_type();   // R1
    start_case();
    push(32'h5000_0003);
    push(32'h0000_0000);
    push(mk_reg(18'h00300, 7'd1, 0, 0));
    push(32'hF00D_0001);
    expect_beat(0, 18'h00300, 0, 32'hF00D_0001, 1, 1);
    finish_case("R1", 0, 2);
  endtask

  initial begin
    #1;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    t_reg_write();
    t_opcode();
    t_noop();
    t_parity();
    t_bad_type();
    t_max_stalled();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule